// File: doc/BRIEF.md
# NAND Page ECC Verdict Unit

After a NAND page has been read into an on-chip page buffer, the controller leaves a per-sector error count for every 512-byte sector in a small bank of packed status words. This unit turns those counts into one verdict for the page. It first waits for the controller's operation-complete event. If the flash-timeout event is also present, it reports a timeout. Otherwise it walks the status slots that belong to the selected buffer. If it meets a sector marked uncorrectable, it reads the page back one byte at a time. It then decides whether the page is merely erased, meaning every byte is 0xFF. Only a page that is not erased is declared a fatal ECC failure.

The verdict comes out as a single-cycle pulse carrying exactly one of three flags: ok, blank or fatal. A two-bit cause tells a timeout apart from an ECC failure. In the same cycle the unit emits a write-one-to-clear strobe carrying the event word it acted on, so the event register can be cleared. The page bytes are fetched through a byte read port with one cycle of latency. The fetch stops as soon as a byte other than 0xFF comes back.

Top module: `nand_ecc_verdict`

## Requirements
- R1: After reset, `done`, `res_ok`, `res_blank`, `res_fatal`, `clr_we` and `rd_en` are all low and `fatal_cause` is 0.
- R2: After `start`, no verdict is produced while `evt_status` bit 31 (operation complete) is low.
- R3: If bit 27 (flash timeout) is set when bit 31 is seen, the verdict is fatal with `fatal_cause` = 1. No slot is examined and no page byte is read.
- R4: `page_sel` 0 selects a 512-byte page (1 slot), 1 selects 2048 bytes (4 slots), and 2 or 3 select 4096 bytes (8 slots). `buf_index` is reduced modulo 16 / slots-per-page. The page's first slot is that reduced index times slots-per-page.
- R5: Slot k sits in word k/4, which is `ecc_words[32*(k/4) +: 32]`, in bits `[(3 - k%4)*8 +: 4]`. Only those low 4 bits of the byte lane are the error count, and a count of 15 marks an uncorrectable sector. The upper nibble of the lane is ignored.
- R6: When no slot of the page holds 15, the verdict is ok with `fatal_cause` = 0 and no page byte is read. Slots outside the page do not matter.
- R7: When an uncorrectable slot is found and every byte of the page is 0xFF, the verdict is blank with `fatal_cause` = 0. All page bytes are read, and no further slots are examined.
- R8: When an uncorrectable slot is found and some page byte is not 0xFF, the verdict is fatal with `fatal_cause` = 2.
- R9: Page bytes are read at offsets 0, 1, 2, … in order, one per cycle. If k is the first offset whose byte is not 0xFF, exactly min(k+2, page bytes) reads are issued.
- R10: `done` is high for exactly one cycle, with exactly one of the three flags. `clr_we` pulses in the same cycle, and `clr_data` equals the `evt_status` value sampled when bit 31 was first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; sampled while idle |
| page_sel | input | 2 | Page size code (0: 512, 1: 2048, 2/3: 4096 bytes) |
| buf_index | input | 4 | Page buffer index |
| ecc_words | input | 128 | Four packed status words, word 0 in the low bits |
| evt_status | input | 32 | Event status word (bit 31 complete, bit 27 timeout) |
| rd_en | output | 1 | Page byte read request |
| rd_addr | output | 12 | Byte offset within the page |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle verdict pulse |
| res_ok | output | 1 | Verdict: no uncorrectable sector |
| res_blank | output | 1 | Verdict: uncorrectable but erased page |
| res_fatal | output | 1 | Verdict: fatal error |
| fatal_cause | output | 2 | 0 none, 1 timeout, 2 ECC |
| clr_we | output | 1 | Write-one-to-clear strobe for the event word |
| clr_data | output | 32 | Event bits to clear |

## Verification
Random status banks seed about one lane in six with a count of 15. Each random case pairs them with a random page size, buffer index and timeout bit. This separates walks that stay inside the selected slot window from those that stray into neighbouring slots. The page contents are drawn three ways: fully erased, one bad byte anywhere, or one bad byte near the start. Comparing the read count against the model tells a correct early stop from a scan that reads too far or too little. Directed cases cover the rest: a lane of 0xF0 that must not count as uncorrectable, a bad last byte, masking of an oversized buffer index, and code 3 behaving as a 4096-byte page.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned SECTOR_BYTES = 512;
  localparam int unsigned MAX_SECTORS  = 8;
  localparam int unsigned PAGE_ADDR_W  = $clog2(SECTOR_BYTES * MAX_SECTORS);

  localparam logic [3:0] CNT_UNCORR  = 4'hF;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_TIMEOUT = 2'd1,
    CAUSE_ECC     = 2'd2
  } fatal_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_WALK = 2'd2,
    ST_SCAN = 2'd3
  } ctl_state_e;

  // Sectors (status slots) covered by one page for a size code.
  function automatic int unsigned sectors_per_page(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      default: return 8;
    endcase
  endfunction

  // First slot of a buffer: index wrapped to the buffers that fit, times span.
  function automatic int unsigned first_slot(input int unsigned idx,
                                             input logic [1:0]  sel,
                                             input int unsigned n_slots);
    int unsigned spp;
    spp = sectors_per_page(sel);
    return (idx % (n_slots / spp)) * spp;
  endfunction

  // Error count of one lane; lane 0 is the most significant byte.
  function automatic logic [3:0] slot_count(input logic [31:0] word,
                                            input logic [1:0]  lane);
    return word[{~lane, 3'b000} +: 4];
  endfunction

  // Offset of the final byte in a page of the given size code.
  function automatic logic [PAGE_ADDR_W-1:0] last_byte(input logic [1:0] sel);
    return PAGE_ADDR_W'(sectors_per_page(sel) * SECTOR_BYTES - 1);
  endfunction

endpackage

// File: rtl/ecc_slot_walker.sv
module ecc_slot_walker
  import nand_ecc_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned SLOT_W    = $clog2(NUM_WORDS * 4)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [SLOT_W-1:0]      first,
  input  logic [SLOT_W-1:0]      last,
  input  logic [NUM_WORDS*32-1:0] words,
  output logic                   hit,
  output logic                   clean
);

  localparam int unsigned WIDX_W = SLOT_W - 2;

  logic [31:0]       word_arr [NUM_WORDS];
  logic              active;
  logic [SLOT_W-1:0] cur;
  logic [SLOT_W-1:0] stop_at;
  logic [31:0]       cur_word;
  logic [3:0]        cur_cnt;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_arr[w] = words[w*32 +: 32];
  end

  always_comb begin
    cur_word = word_arr[cur[SLOT_W-1 -: WIDX_W]];
    cur_cnt  = slot_count(cur_word, cur[1:0]);
  end

  assign hit   = active && (cur_cnt == CNT_UNCORR);
  assign clean = active && (cur_cnt != CNT_UNCORR) && (cur == stop_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur     <= '0;
      stop_at <= '0;
    end else if (load) begin
      active  <= 1'b1;
      cur     <= first;
      stop_at <= last;
    end else if (active) begin
      if (hit || clean) active <= 1'b0;
      else              cur    <= cur + 1'b1;
    end
  end

  // R6: a walk never runs past the page's last slot
  p_walk_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && !$past(hit) && !$past(clean) |-> $past(cur) != $past(stop_at));

endmodule

// File: rtl/erased_page_scanner.sv
module erased_page_scanner
  import nand_ecc_pkg::*;
#(
  parameter int unsigned ADDR_W = PAGE_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              blank_hit,
  output logic              dirty_hit
);

  logic              issuing;
  logic              pend;
  logic              pend_last;
  logic [ADDR_W-1:0] iss_addr;
  logic [ADDR_W-1:0] stop_addr;

  assign rd_en     = issuing;
  assign rd_addr   = iss_addr;
  assign dirty_hit = pend && (rd_data != ERASED_BYTE);
  assign blank_hit = pend && pend_last && (rd_data == ERASED_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing   <= 1'b0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      iss_addr  <= '0;
      stop_addr <= '0;
    end else if (load) begin
      issuing   <= 1'b1;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      iss_addr  <= '0;
      stop_addr <= last_addr;
    end else begin
      pend      <= issuing;
      pend_last <= issuing && (iss_addr == stop_addr);
      if (issuing) begin
        iss_addr <= iss_addr + 1'b1;
        if (iss_addr == stop_addr) issuing <= 1'b0;
      end
      if (dirty_hit) begin
        issuing <= 1'b0;
        pend    <= 1'b0;
      end
    end
  end

  // R9: reads stay inside the page
  p_rd_in_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr <= stop_addr);

  // R9: back-to-back reads walk upward by one byte
  p_rd_sequential_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) && !$past(load) |-> rd_addr == $past(rd_addr) + 1'b1);

  // R9: reads stop once the scan has decided
  p_rd_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_hit || dirty_hit) && !load |=> !rd_en);

endmodule

// File: rtl/nand_ecc_verdict.sv
module nand_ecc_verdict
  import nand_ecc_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned OPC_BIT   = 31,
  parameter int unsigned FTO_BIT   = 27,
  parameter int unsigned SLOT_W    = $clog2(NUM_WORDS * 4),
  parameter int unsigned ADDR_W    = PAGE_ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              page_sel,
  input  logic [SLOT_W-1:0]       buf_index,
  input  logic [NUM_WORDS*32-1:0] ecc_words,
  input  logic [31:0]             evt_status,
  output logic                    rd_en,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [7:0]              rd_data,
  output logic                    done,
  output logic                    res_ok,
  output logic                    res_blank,
  output logic                    res_fatal,
  output logic [1:0]              fatal_cause,
  output logic                    clr_we,
  output logic [31:0]             clr_data
);

  localparam int unsigned NUM_SLOTS = NUM_WORDS * 4;

  ctl_state_e        state;
  fatal_cause_e      cause_q;
  logic [1:0]        sel_q;
  logic [SLOT_W-1:0] idx_q;
  logic [31:0]       stat_q;

  // named internal events
  logic              opc_seen;
  logic              tmo_seen;
  logic              walk_load;
  logic              walk_hit;
  logic              walk_clean;
  logic              scan_load;
  logic              scan_blank;
  logic              scan_dirty;
  logic [SLOT_W-1:0] win_first;
  logic [SLOT_W-1:0] win_last;
  logic [ADDR_W-1:0] page_last;

  assign opc_seen  = (state == ST_WAIT) && evt_status[OPC_BIT];
  assign tmo_seen  = opc_seen && evt_status[FTO_BIT];
  assign walk_load = opc_seen && !tmo_seen;
  assign scan_load = (state == ST_WALK) && walk_hit;

  always_comb begin
    win_first = SLOT_W'(first_slot(32'(idx_q), sel_q, NUM_SLOTS));
    win_last  = win_first + SLOT_W'(sectors_per_page(sel_q) - 1);
    page_last = ADDR_W'(last_byte(sel_q));
  end

  ecc_slot_walker #(
    .NUM_WORDS (NUM_WORDS),
    .SLOT_W    (SLOT_W)
  ) i_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (walk_load),
    .first (win_first),
    .last  (win_last),
    .words (ecc_words),
    .hit   (walk_hit),
    .clean (walk_clean)
  );

  erased_page_scanner #(
    .ADDR_W (ADDR_W)
  ) i_scanner (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (scan_load),
    .last_addr (page_last),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .blank_hit (scan_blank),
    .dirty_hit (scan_dirty)
  );

  assign fatal_cause = cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      idx_q     <= '0;
      stat_q    <= '0;
      done      <= 1'b0;
      res_ok    <= 1'b0;
      res_blank <= 1'b0;
      res_fatal <= 1'b0;
      cause_q   <= CAUSE_NONE;
      clr_we    <= 1'b0;
      clr_data  <= '0;
    end else begin
      done      <= 1'b0;
      res_ok    <= 1'b0;
      res_blank <= 1'b0;
      res_fatal <= 1'b0;
      cause_q   <= CAUSE_NONE;
      clr_we    <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          sel_q <= page_sel;
          idx_q <= buf_index;
          state <= ST_WAIT;
        end
        ST_WAIT: if (opc_seen) begin
          stat_q <= evt_status;
          if (tmo_seen) begin
            done      <= 1'b1;
            res_fatal <= 1'b1;
            cause_q   <= CAUSE_TIMEOUT;
            clr_we    <= 1'b1;
            clr_data  <= evt_status;
            state     <= ST_IDLE;
          end else begin
            state <= ST_WALK;
          end
        end
        ST_WALK: if (walk_hit) begin
          state <= ST_SCAN;
        end else if (walk_clean) begin
          done     <= 1'b1;
          res_ok   <= 1'b1;
          clr_we   <= 1'b1;
          clr_data <= stat_q;
          state    <= ST_IDLE;
        end
        ST_SCAN: if (scan_blank) begin
          done      <= 1'b1;
          res_blank <= 1'b1;
          clr_we    <= 1'b1;
          clr_data  <= stat_q;
          state     <= ST_IDLE;
        end else if (scan_dirty) begin
          done      <= 1'b1;
          res_fatal <= 1'b1;
          cause_q   <= CAUSE_ECC;
          clr_we    <= 1'b1;
          clr_data  <= stat_q;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: a verdict carries exactly one flag
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({res_ok, res_blank, res_fatal}));

  // R10: flags are silent between verdicts
  p_quiet_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(res_ok || res_blank || res_fatal));

  // R3 / R8: a fatal verdict names its cause, others name none
  p_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_fatal == (fatal_cause != CAUSE_NONE)));

  // R2: nothing is decided while completion is absent
  p_wait_opc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && !evt_status[OPC_BIT] |=> !done);

  // R10: the cleared word always includes the completion event
  p_clr_opc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |-> clr_data[OPC_BIT]);

  // R6: no page read unless a scan is under way
  p_read_only_in_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> state == ST_SCAN);

endmodule

// File: tb/test_nand_ecc_verdict.sv
module test_nand_ecc_verdict;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   page_sel = '0;
  logic [3:0]   buf_index = '0;
  logic [127:0] ecc_words = '0;
  logic [31:0]  evt_status = '0;
  logic         rd_en;
  logic [11:0]  rd_addr;
  logic [7:0]   rd_data = '0;
  logic         done, res_ok, res_blank, res_fatal, clr_we;
  logic [1:0]   fatal_cause;
  logic [31:0]  clr_data;

  int n_checks = 0;
  int n_err    = 0;
  int rd_cnt   = 0;
  int rd_base  = 0;
  int order_err = 0;
  bit finished = 0;

  logic [7:0] mem [4096];

  always #5 clk = ~clk;

  nand_ecc_verdict i_nand_ecc_verdict (
    .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
    .buf_index(buf_index), .ecc_words(ecc_words), .evt_status(evt_status),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .res_ok(res_ok), .res_blank(res_blank), .res_fatal(res_fatal),
    .fatal_cause(fatal_cause), .clr_we(clr_we), .clr_data(clr_data)
  );

  // page buffer model: one cycle read latency, counts and orders reads
  always @(posedge clk) begin
    rd_data <= rd_en ? mem[rd_addr] : 8'h00;
    if (rd_en) begin
      if (int'(rd_addr) != rd_cnt - rd_base) order_err <= order_err + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check_eq(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_mem(input int pb, input int bad_pos, input logic [7:0] bad_val);
    for (int j = 0; j < 4096; j++) mem[j] = 8'hFF;
    if (bad_pos >= 0 && bad_pos < pb) mem[bad_pos] = bad_val;
  endtask

  // kind: 0 ok, 1 blank, 2 fatal ECC, 3 timeout
  function automatic void predict(input logic [127:0] w, input int idx, input int sel,
                                  input logic [31:0] st, output int kind, output int reads);
    int spp, pb, base;
    spp   = (sel == 0) ? 1 : (sel == 1) ? 4 : 8;
    pb    = spp * 512;
    base  = (idx % (16 / spp)) * spp;
    reads = 0;
    kind  = 0;
    if (st[27]) begin
      kind = 3;
      return;
    end
    for (int s = base; s < base + spp; s++) begin
      logic [7:0] lane;
      lane = 8'(w >> (32 * (s / 4) + 24 - 8 * (s % 4)));
      if (lane[3:0] == 4'hF) begin
        kind = 1;
        break;
      end
    end
    if (kind == 1) begin
      reads = pb;
      for (int j = 0; j < pb; j++) begin
        if (mem[j] != 8'hFF) begin
          kind  = 2;
          reads = (j + 2 < pb) ? j + 2 : pb;
          break;
        end
      end
    end
  endfunction

  task automatic run_case(input string tag, input logic [127:0] w, input int idx,
                          input int sel, input logic [31:0] st);
    int kind, reads, got, guard;
    bit seen;
    logic [31:0] stat;
    stat = st | 32'h8000_0000;
    predict(w, idx, sel, stat, kind, reads);
    @(negedge clk);
    ecc_words  = w;
    buf_index  = 4'(idx);
    page_sel   = 2'(sel);
    evt_status = st & 32'h7FFF_FFFF;
    rd_base    = rd_cnt;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen  = 0;
    repeat (3) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check_eq({"R2 verdict before completion ", tag}, seen, 0);
    evt_status = stat;
    guard = 0;
    while (!done && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
    check_eq({"R10 verdict produced ", tag}, done, 1);
    got = res_ok ? 0 : res_blank ? 1 :
          (res_fatal && fatal_cause == 2'd2) ? 2 :
          (res_fatal && fatal_cause == 2'd1) ? 3 : 9;
    case (kind)
      0: check_eq({"R6 ok verdict ", tag}, got, kind);
      1: check_eq({"R7 blank verdict ", tag}, got, kind);
      2: check_eq({"R8 fatal ECC verdict ", tag}, got, kind);
      default: check_eq({"R3 timeout verdict ", tag}, got, kind);
    endcase
    check_eq({"R10 clear strobe ", tag}, clr_we, 1);
    check_eq({"R10 cleared word ", tag}, clr_data, stat);
    check_eq({"R9 read count ", tag}, rd_cnt - rd_base, reads);
    check_eq({"R9 read order ", tag}, order_err, 0);
    evt_status = '0;
    @(negedge clk);
    check_eq({"R10 single-cycle pulse ", tag}, done, 0);
  endtask

  initial begin
    logic [127:0] w;
    int sel, pb, mode;
    void'($urandom(32'd20240611));
    fill_mem(4096, -1, 8'h00);
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 done low", done, 0);
    check_eq("R1 rd_en low", rd_en, 0);
    check_eq("R1 clr_we low", clr_we, 0);
    check_eq("R1 flags low", {res_ok, res_blank, res_fatal}, 0);
    check_eq("R1 cause zero", fatal_cause, 0);
    rst_n = 1'b1;

    // R3: timeout wins over uncorrectable slots
    run_case("timeout", {128{1'b1}}, 0, 0, 32'h0800_0000);
    // R5/R6: lane 0xF0 is count 0; out-of-window 0x0F lanes are ignored
    fill_mem(512, 3, 8'h00);
    run_case("R5 upper nibble", 128'h0F0F_F00F, 2, 0, 32'h0000_0001);
    // R5/R7: lane 0x0F is uncorrectable, erased page
    fill_mem(512, -1, 8'h00);
    run_case("R5 low nibble erased", 128'h0000_0F00, 2, 0, 32'h0000_0000);
    // R8/R9: dirty first byte of a 4K page, slot 15
    fill_mem(4096, 0, 8'h7E);
    run_case("R9 bad first byte", 128'h0000_000F << 96, 1, 2, 32'h0);
    // R8/R9: dirty last byte of a 2K page
    fill_mem(2048, 2047, 8'hFE);
    run_case("R9 bad last byte", 128'h0F00_0000, 0, 1, 32'h0);
    // R4: index 5 on a 2K page wraps to buffer 1 (slots 4..7)
    fill_mem(2048, 3, 8'h00);
    run_case("R4 index wrap", 128'h0F00_0000 << 32, 5, 1, 32'h0);
    // R4: code 3 acts as a 4K page
    fill_mem(4096, -1, 8'h00);
    run_case("R4 size code 3", 128'h0000_000F << 32, 0, 3, 32'h0);

    for (int n = 0; n < 24; n++) begin
      w = '0;
      for (int s = 0; s < 16; s++) begin
        logic [7:0] lane;
        lane = 8'($urandom);
        if ($urandom % 6 == 0) lane[3:0] = 4'hF;
        else if (lane[3:0] == 4'hF) lane[3:0] = 4'hE;
        w[s*8 +: 8] = lane;
      end
      sel  = int'($urandom % 4);
      pb   = (sel == 0) ? 512 : (sel == 1) ? 2048 : 4096;
      mode = int'($urandom % 3);
      if (mode == 0)      fill_mem(pb, -1, 8'h00);
      else if (mode == 1) fill_mem(pb, int'($urandom % pb), 8'h5A);
      else                fill_mem(pb, int'($urandom % 8), 8'h00);
      run_case("random", w, int'($urandom % 16), sel,
               (($urandom % 7) == 0) ? ($urandom | 32'h0800_0000)
                                     : ($urandom & 32'hF7FF_FFFF));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule